// File: doc/BRIEF.md
# Parallel-load serial-out shift register

This block is an eight-stage shift register that either captures a parallel word or moves its contents one stage per shift clock. The last stage is driven out twice: once true and once inverted. Everything runs on one fast system clock. The two external clock-pulse inputs, the active-low load input and the serial data input are sampled on that clock through two-flop synchronizers.

The shift clock is the logical OR of the two clock-pulse inputs. Either input can therefore act as the clock, and the other as an active-high inhibit. Holding either input high freezes the register. The load input is level-sensitive and overrides both clocks. While it is asserted, the register tracks the parallel word.

One of the two inputs is set at build time as the inhibit. If that input rises while the other clock input is low, it causes a shift. The block raises a one-cycle warning pulse when this happens, because it usually means an unintended double clock.

Top module: `piso_shifter`

## Requirements
- R1: A synchronous active-high reset clears all stages to 0, so `serOut` is 0 and `serOutN` is 1.
- R2: While `loadN` is low, every stage i takes `parIn[i]` whatever the clock inputs do. A change on `loadN`, `clkA` or `clkB` takes effect on the third system clock edge after it.
- R3: The load is transparent. If `parIn` changes while `loadN` stays low, the stages follow the new word.
- R4: While `loadN` is high, each rising edge of (`clkA` OR `clkB`) shifts the register once. `serIn` enters stage 0, stage i moves to stage i+1, and the old stage 7 is lost. After a load, `serOut` therefore presents `parIn[7]` down to `parIn[0]` on successive shifts, followed by the serial bits in the order they were shifted in.
- R5: While either clock input is held high, the other input may toggle and the register contents do not change. A falling OR does not shift.
- R6: A rising edge on either clock input while the other is low is a shift edge. The two inputs are interchangeable as the clock.
- R7: `serOutN` is always the complement of `serOut`.
- R8: With the default `INHIBIT_SEL` = 0, `clkB` is the inhibit. `inhibitWarn` is high for exactly one system cycle when a rising `clkB` causes a shift while `clkA` is low. It stays low for shifts caused by `clkA`, and for a `clkB` rise while `clkA` is high.
- R9: Load wins over shift, and no shift happens in a cycle that loads. A clock rise during the load, with the clock still high when the load is released, causes no shift. The first shift after release starts from the last loaded word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clkA | input | 1 | Clock-pulse input A, asynchronous |
| clkB | input | 1 | Clock-pulse input B, asynchronous (inhibit by default) |
| loadN | input | 1 | Active-low, level-sensitive parallel load |
| serIn | input | 1 | Serial data into stage 0 |
| parIn | input | WIDTH | Parallel word, bit i goes to stage i |
| serOut | output | 1 | Last stage |
| serOutN | output | 1 | Complement of last stage |
| inhibitWarn | output | 1 | One-cycle pulse on a shift caused by the inhibit input |

## Verification
The hardest states to reach from the ports are the ones where the two clock inputs overlap. One case is an inhibit raised while the clock is already high, followed by toggling of the clock. The other is a clock that rises during a load and is still high when the load is released. The bench drives these overlaps in explicit order, waiting past the synchronizer latency between steps. It then shifts the whole register out through `serOut` to show that no extra shift happened. It also counts `inhibitWarn` cycles to separate shifts caused by the inhibit input from ordinary clock shifts.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef struct packed {
    logic load;
    logic shift;
    logic serBit;
  } ctlStrobe_t;
endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INHIBIT_SEL = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clkA,
  input  logic       clkB,
  input  logic       loadN,
  input  logic       serIn,
  output ctlStrobe_t strobe,
  output logic       inhibitWarn
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] aSync, bSync, lSync, sSync;
  logic aNow, bNow, lNow, sNow;
  logic orNow, orPrev, inhNow, inhPrev, otherNow;

  always_ff @(posedge clk) begin
    if (rst) begin
      aSync <= '0;
      bSync <= '0;
      lSync <= '1;
      sSync <= '0;
    end else begin
      aSync <= {aSync[TOP-1:0], clkA};
      bSync <= {bSync[TOP-1:0], clkB};
      lSync <= {lSync[TOP-1:0], loadN};
      sSync <= {sSync[TOP-1:0], serIn};
    end
  end

  assign aNow  = aSync[TOP];
  assign bNow  = bSync[TOP];
  assign lNow  = lSync[TOP];
  assign sNow  = sSync[TOP];
  assign orNow = aNow | bNow;

  generate
    if (INHIBIT_SEL == 0) begin : g_inhB
      assign inhNow   = bNow;
      assign otherNow = aNow;
    end else begin : g_inhA
      assign inhNow   = aNow;
      assign otherNow = bNow;
    end
  endgenerate

  assign strobe.load   = ~lNow;
  assign strobe.shift  = lNow & orNow & ~orPrev;
  assign strobe.serBit = sNow;

  always_ff @(posedge clk) begin
    if (rst) begin
      orPrev      <= 1'b0;
      inhPrev     <= 1'b0;
      inhibitWarn <= 1'b0;
    end else begin
      orPrev      <= orNow;
      inhPrev     <= inhNow;
      inhibitWarn <= strobe.shift & inhNow & ~inhPrev & ~otherNow;
    end
  end
endmodule

// File: rtl/piso_datapath.sv
module piso_datapath
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobe_t       strobe,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] stageVec,
  output logic             serOut,
  output logic             serOutN
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      logic shiftSrc;
      if (i == 0) begin : g_head
        assign shiftSrc = strobe.serBit;
      end else begin : g_body
        assign shiftSrc = stageVec[i-1];
      end
      always_ff @(posedge clk) begin
        if (rst)               stageVec[i] <= 1'b0;
        else if (strobe.load)  stageVec[i] <= parIn[i];
        else if (strobe.shift) stageVec[i] <= shiftSrc;
      end
    end
  endgenerate

  assign serOut  = stageVec[WIDTH-1];
  assign serOutN = ~stageVec[WIDTH-1];
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
  import piso_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int INHIBIT_SEL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clkA,
  input  logic             clkB,
  input  logic             loadN,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             serOut,
  output logic             serOutN,
  output logic             inhibitWarn
);
  ctlStrobe_t       strobe;
  logic [WIDTH-1:0] stageVec;

  piso_ctrl #(.SYNC_STAGES(SYNC_STAGES), .INHIBIT_SEL(INHIBIT_SEL)) u_ctrl (
    .clk(clk), .rst(rst), .clkA(clkA), .clkB(clkB), .loadN(loadN),
    .serIn(serIn), .strobe(strobe), .inhibitWarn(inhibitWarn)
  );

  piso_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .parIn(parIn),
    .stageVec(stageVec), .serOut(serOut), .serOutN(serOutN)
  );
endmodule

// File: rtl/piso_checker.sv
module piso_checker
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input ctlStrobe_t       strobe,
  input logic [WIDTH-1:0] parIn,
  input logic [WIDTH-1:0] stageVec,
  input logic             inhibitWarn
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> stageVec == '0);
  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> stageVec == $past(parIn));
  // R4
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.shift |=> stageVec == {$past(stageVec[WIDTH-2:0]), $past(strobe.serBit)});
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.load && !strobe.shift) |=> $stable(stageVec));
  // R8
  warn_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    inhibitWarn |=> !inhibitWarn);
  // R9
  no_load_shift_chk: assert property (@(posedge clk) disable iff (rst)
    !(strobe.load && strobe.shift));
endmodule

bind piso_shifter piso_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .parIn(parIn),
  .stageVec(stageVec), .inhibitWarn(inhibitWarn)
);

// File: tb/piso_shifter_test.sv
module piso_shifter_test;
  localparam int CLK_P = 10;
  localparam int W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic clkA = 1'b0, clkB = 1'b0, loadN = 1'b1, serIn = 1'b0;
  logic [W-1:0] parIn = '0;
  logic serOut, serOutN, inhibitWarn;
  int checks = 0, fails = 0, warnCycles = 0;

  piso_shifter uut (
    .clk(clk), .rst(rst), .clkA(clkA), .clkB(clkB), .loadN(loadN),
    .serIn(serIn), .parIn(parIn), .serOut(serOut), .serOutN(serOutN),
    .inhibitWarn(inhibitWarn)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) if (inhibitWarn) warnCycles <= warnCycles + 1;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkOut(input string tag, input logic exp);
    check(tag, serOut, exp);
    check({tag, " R7"}, serOutN, !exp);
  endtask

  task automatic pulse(input bit useB);
    if (useB) clkB = 1'b1; else clkA = 1'b1;
    step(4);
    if (useB) clkB = 1'b0; else clkA = 1'b0;
    step(4);
  endtask

  task automatic loadWord(input logic [W-1:0] w);
    parIn = w; loadN = 1'b0; step(4);
    loadN = 1'b1; step(4);
  endtask

  task automatic readOut(input string tag, input logic [W-1:0] word,
                         input logic [W-1:0] inBits, input bit useB);
    logic [W-1:0] cur;
    cur = word;
    for (int i = 0; i < W; i++) begin
      checkOut(tag, cur[W-1]);
      serIn = inBits[W-1-i];
      pulse(useB);
      cur = {cur[W-2:0], serIn};
    end
  endtask

  task automatic t_reset();
    step(3); rst = 1'b0; step(2);
    checkOut("R1 reset", 1'b0);
  endtask

  task automatic t_load();
    parIn = 8'hA5; loadN = 1'b0; step(4);
    checkOut("R2 load", 1'b1);
    clkA = 1'b1; step(4); clkA = 1'b0; step(4);
    clkB = 1'b1; step(4); clkB = 1'b0; step(4);
    checkOut("R2 clocks ignored", 1'b1);
    parIn = 8'h3C; step(2);
    checkOut("R3 follow", 1'b0);
    parIn = 8'h96; step(2);
    loadN = 1'b1; step(4);
    warnCycles = 0;
    readOut("R4 shiftA", 8'h96, 8'hC3, 1'b0);
    readOut("R4 serial in", 8'hC3, 8'h00, 1'b0);
    check("R8 no warn on clkA", warnCycles, 0);
  endtask

  task automatic t_clkB();
    loadWord(8'h5A);
    warnCycles = 0;
    readOut("R6 shiftB", 8'h5A, 8'hE1, 1'b1);
    check("R8 warn per B shift", warnCycles, W);
    readOut("R6 shiftB in", 8'hE1, 8'h00, 1'b1);
  endtask

  task automatic t_inhibit();
    loadWord(8'hF0);
    warnCycles = 0;
    serIn = 1'b0;
    clkA = 1'b1; step(4);
    clkB = 1'b1; step(4);
    for (int i = 0; i < 3; i++) begin
      clkA = 1'b0; step(4); clkA = 1'b1; step(4);
    end
    checkOut("R5 held", 1'b1);
    clkA = 1'b0; step(4);
    clkB = 1'b0; step(4);
    check("R8 no warn when A high", warnCycles, 0);
    readOut("R5 contents", 8'hE0, 8'h00, 1'b0);
  endtask

  task automatic t_loadWins();
    parIn = 8'h81; loadN = 1'b0; step(4);
    clkA = 1'b1; step(4);
    loadN = 1'b1; step(4);
    checkOut("R9 no shift at release", 1'b1);
    clkA = 1'b0; step(4);
    readOut("R9 first shift", 8'h81, 8'h00, 1'b0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    t_reset();
    t_load();
    t_clkB();
    t_inhibit();
    t_loadWins();
    finishRun();
  end
endmodule